// File: doc/BRIEF.md
# Timer Interrupt Flag Unit

This block keeps the four interrupt status flags of a 16-bit timer/counter: input capture, two output compare channels (A and B) and overflow. It watches the running counter value, the two compare values and the capture register value. It also takes a capture event strobe from the synchronised pin, an overflow strobe from the counter, a mode select and forced-compare strobes. From these it decides when each flag becomes set. The counter, the waveform logic and the pin synchroniser live outside the block.

A flag clears when the interrupt controller sends the acknowledge pulse for that flag's vector, or when software writes a one to the flag's bit through the register write port. Each interrupt request is the flag gated by an enable-mask bit and leaves the block from a register. An 8-bit read-back presents the flags at their register positions.

Top module: `tmr_irq_flags`

## Requirements
- R1: While `rst` is high, and at the first falling edge after it, `flags`, `irq` and `rd_data` are all zero.
- R2: With `cap_is_top` low, a one-cycle `cap_evt` pulse sets the capture flag (`flags[3]`), and the flag is visible after the next rising edge. With `cap_is_top` high, `cap_evt` is ignored.
- R3: With `cap_is_top` high, the capture flag is set in the timer cycle after the counter first equals `cap_val`. It is visible after the second rising edge that sees the match.
- R4: Compare flags A (`flags[2]`) and B (`flags[1]`) are set in the timer cycle after `cnt_val` first equals that channel's compare value. A match that is held for many cycles sets the flag only once.
- R5: A forced-compare strobe (`force_a`, `force_b`) never sets a compare flag. A strobe in the first cycle of a match uses up that match, so the flag stays clear.
- R6: In mode 0 (normal) and mode 1 (clear on compare), `ovf_stb` sets the overflow flag (`flags[0]`), and the flag is visible after the next rising edge.
- R7: In modes 2 and 3 (PWM), `ovf_stb` is ignored. The overflow flag is set in the timer cycle after `cnt_val` becomes zero.
- R8: An `ack[i]` pulse clears `flags[i]`. The order is overflow = 0, compare B = 1, compare A = 2, capture = 3.
- R9: With `wr_en` high, a one in `wr_data` bit 5, 4, 3 or 2 clears the capture, compare A, compare B or overflow flag. Zeros and bits 7, 6, 1 and 0 leave the flags as they are.
- R10: When a set event and a clear (acknowledge or write-one) reach the same flag in the same cycle, the flag ends up set.
- R11: After each rising edge, `irq[i]` equals the new `flags[i]` ANDed with `irq_mask[i]` as sampled at that edge.
- R12: `rd_data` shows the capture flag at bit 5, compare A at bit 4, compare B at bit 3 and overflow at bit 2. All other bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_val | input | 16 | Current counter value |
| cmp_a_val | input | 16 | Compare value, channel A |
| cmp_b_val | input | 16 | Compare value, channel B |
| cap_val | input | 16 | Capture register value, used as TOP |
| cap_evt | input | 1 | Synchronised capture event strobe |
| cap_is_top | input | 1 | Capture register acts as TOP |
| mode | input | 2 | 0 normal, 1 clear on compare, 2/3 PWM |
| ovf_stb | input | 1 | Counter overflow strobe |
| force_a | input | 1 | Forced compare strobe, channel A |
| force_b | input | 1 | Forced compare strobe, channel B |
| ack | input | 4 | Vector acknowledge pulses, one per flag |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data (one clears) |
| irq_mask | input | 4 | Interrupt enable per flag |
| flags | output | 4 | Flag register {cap, cmpA, cmpB, ovf} |
| irq | output | 4 | Masked interrupt requests (registered) |
| rd_data | output | 8 | Flag register read-back |

## Verification
The capture pin event, the overflow strobe in modes 0 and 1, acknowledges and writes all take effect at the first rising edge after they are applied. Compare matches, the capture-at-TOP match and the PWM bottom detection pass through one extra register, so their flag appears after the second edge. `irq` changes at the same edge as its flag, with the mask taken from that edge, and `rd_data` follows the flags with no delay. The bench drives inputs just after a falling edge and samples every output at the next falling edge. A per-cycle reference model keeps the same one-edge and two-edge pipeline and is compared every cycle. Directed cases also state by hand the cycle in which each flag must rise.

// File: rtl/tmr_flag_pkg.sv
package tmr_flag_pkg;

  localparam int NFLAG    = 4;
  localparam int FLAG_LSB = 2;

  typedef enum logic [1:0] {
    FL_OVF  = 2'd0,
    FL_CMPB = 2'd1,
    FL_CMPA = 2'd2,
    FL_CAP  = 2'd3
  } flag_idx_e;

  typedef enum logic [1:0] {
    MD_NORMAL  = 2'd0,
    MD_CLR_CMP = 2'd1,
    MD_PWM_FIX = 2'd2,
    MD_PWM_VAR = 2'd3
  } tmr_mode_e;

endpackage

// File: rtl/match_edge.sv
// Registered equality detector: one pulse on the first cycle of a match,
// delivered one clock later. A held match does not pulse again.
module match_edge #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         absorb,
  output logic         pulse
);
  logic eq_now;
  logic eq_q;

  assign eq_now = (a == b);

  always_ff @(posedge clk) begin
    if (rst) begin
      eq_q  <= 1'b0;
      pulse <= 1'b0;
    end else begin
      eq_q  <= eq_now;
      pulse <= eq_now & ~eq_q & ~absorb;
    end
  end
endmodule

// File: rtl/flag_cell.sv
// One status flag with set-priority over clear, plus its masked request.
module flag_cell (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  input  logic mask,
  output logic flag_q,
  output logic irq_q
);
  logic flag_d;

  assign flag_d = set | (flag_q & ~clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      irq_q  <= flag_d & mask;
    end
  end
endmodule

// File: rtl/tmr_irq_flags.sv
module tmr_irq_flags
  import tmr_flag_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic [CNT_W-1:0] cmp_a_val,
  input  logic [CNT_W-1:0] cmp_b_val,
  input  logic [CNT_W-1:0] cap_val,
  input  logic             cap_evt,
  input  logic             cap_is_top,
  input  logic [1:0]       mode,
  input  logic             ovf_stb,
  input  logic             force_a,
  input  logic             force_b,
  input  logic [NFLAG-1:0] ack,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic [NFLAG-1:0] irq_mask,
  output logic [NFLAG-1:0] flags,
  output logic [NFLAG-1:0] irq,
  output logic [REG_W-1:0] rd_data
);
  localparam int NCMP   = 2;
  localparam int FLD_HI = FLAG_LSB + NFLAG;

  logic [CNT_W-1:0] cmp_vals [NCMP];
  logic [NCMP-1:0]  cmp_force;
  logic [NCMP-1:0]  cmp_pulse;
  logic             top_pulse;
  logic             bot_pulse;
  logic [NFLAG-1:0] set_vec;
  logic [NFLAG-1:0] clr_vec;
  logic             ovf_direct;
  tmr_mode_e        md;
  logic             unused_wr_bits;

  assign cmp_vals[0] = cmp_a_val;
  assign cmp_vals[1] = cmp_b_val;
  assign cmp_force   = {force_b, force_a};

  // Compare channels: index 0 -> A, index 1 -> B
  for (genvar ch = 0; ch < NCMP; ch++) begin : g_cmp
    match_edge #(.W(CNT_W)) u_det (
      .clk    (clk),
      .rst    (rst),
      .a      (cnt_val),
      .b      (cmp_vals[ch]),
      .absorb (cmp_force[ch]),
      .pulse  (cmp_pulse[ch])
    );
  end

  // Counter reaching TOP held in the capture register
  match_edge #(.W(CNT_W)) u_top (
    .clk    (clk),
    .rst    (rst),
    .a      (cnt_val),
    .b      (cap_val),
    .absorb (1'b0),
    .pulse  (top_pulse)
  );

  // Counter reaching BOTTOM, overflow point in PWM modes
  match_edge #(.W(CNT_W)) u_bot (
    .clk    (clk),
    .rst    (rst),
    .a      (cnt_val),
    .b      ('0),
    .absorb (1'b0),
    .pulse  (bot_pulse)
  );

  assign md         = tmr_mode_e'(mode);
  assign ovf_direct = (md == MD_NORMAL) || (md == MD_CLR_CMP);

  always_comb begin
    set_vec          = '0;
    set_vec[FL_CAP]  = cap_is_top ? top_pulse : cap_evt;
    set_vec[FL_CMPA] = cmp_pulse[0];
    set_vec[FL_CMPB] = cmp_pulse[1];
    set_vec[FL_OVF]  = ovf_direct ? ovf_stb : bot_pulse;
  end

  assign clr_vec = ack | ({NFLAG{wr_en}} & wr_data[FLD_HI-1:FLAG_LSB]);

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    flag_cell u_cell (
      .clk    (clk),
      .rst    (rst),
      .set    (set_vec[i]),
      .clr    (clr_vec[i]),
      .mask   (irq_mask[i]),
      .flag_q (flags[i]),
      .irq_q  (irq[i])
    );
  end

  always_comb begin
    rd_data                       = '0;
    rd_data[FLD_HI-1:FLAG_LSB]    = flags;
  end

  assign unused_wr_bits = ^{wr_data[REG_W-1:FLD_HI], wr_data[FLAG_LSB-1:0]};

endmodule

// File: rtl/tmr_irq_flags_chk.sv
module tmr_irq_flags_chk
  import tmr_flag_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic [NFLAG-1:0] ack,
  input logic             wr_en,
  input logic [7:0]       wr_data,
  input logic [NFLAG-1:0] irq_mask,
  input logic [NFLAG-1:0] flags,
  input logic [NFLAG-1:0] irq,
  input logic [NFLAG-1:0] set_vec
);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (flags == '0) && (irq == '0));

  p_irq_mask_r11: assert property (@(posedge clk) disable iff (rst)
    irq == (flags & $past(irq_mask)));

  p_cmp_a_once_r4: assert property (@(posedge clk) disable iff (rst)
    set_vec[FL_CMPA] |=> !set_vec[FL_CMPA]);

  p_cmp_b_once_r4: assert property (@(posedge clk) disable iff (rst)
    set_vec[FL_CMPB] |=> !set_vec[FL_CMPB]);

  for (genvar i = 0; i < NFLAG; i++) begin : g_bit
    p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
      set_vec[i] |=> flags[i]);

    p_ack_clear_r8: assert property (@(posedge clk) disable iff (rst)
      (ack[i] && !set_vec[i]) |=> !flags[i]);

    p_w1c_r9: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_data[FLAG_LSB+i] && !set_vec[i]) |=> !flags[i]);

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
      (flags[i] && !ack[i] && !(wr_en && wr_data[FLAG_LSB+i])) |=> flags[i]);

    p_no_spurious_r2: assert property (@(posedge clk) disable iff (rst)
      (!flags[i] && !set_vec[i]) |=> !flags[i]);
  end

endmodule

bind tmr_irq_flags tmr_irq_flags_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .ack      (ack),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .irq_mask (irq_mask),
  .flags    (flags),
  .irq      (irq),
  .set_vec  (set_vec)
);

// File: tb/tmr_irq_flags_test.sv
module tmr_irq_flags_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cnt_val = '0, cmp_a_val = 16'd9, cmp_b_val = 16'd9, cap_val = 16'd9;
  logic        cap_evt = 0, cap_is_top = 0, ovf_stb = 0, force_a = 0, force_b = 0, wr_en = 0;
  logic [1:0]  mode = 2'd0;
  logic [3:0]  ack = '0, irq_mask = '0;
  logic [7:0]  wr_data = '0;
  logic [3:0]  flags, irq;
  logic [7:0]  rd_data;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference model state
  logic [3:0] m_flags = '0, m_irq = '0;
  logic [3:0] h_eq = '0, h_pend = '0; // 0 cmpA, 1 cmpB, 2 top, 3 bottom

  always #(CLK_P/2) clk = ~clk;

  tmr_irq_flags uut (
    .clk(clk), .rst(rst), .cnt_val(cnt_val), .cmp_a_val(cmp_a_val),
    .cmp_b_val(cmp_b_val), .cap_val(cap_val), .cap_evt(cap_evt),
    .cap_is_top(cap_is_top), .mode(mode), .ovf_stb(ovf_stb),
    .force_a(force_a), .force_b(force_b), .ack(ack), .wr_en(wr_en),
    .wr_data(wr_data), .irq_mask(irq_mask), .flags(flags), .irq(irq),
    .rd_data(rd_data)
  );

  function automatic logic [3:0] set_events(logic [3:0] pend);
    logic [3:0] s;
    s[3] = cap_is_top ? pend[2] : cap_evt;
    s[2] = pend[0];
    s[1] = pend[1];
    s[0] = (mode < 2'd2) ? ovf_stb : pend[3];
    return s;
  endfunction

  function automatic logic [3:0] clr_events();
    return ack | ({4{wr_en}} & wr_data[5:2]);
  endfunction

  always @(posedge clk) begin
    logic [3:0] s, eqn, nf;
    if (rst) begin
      m_flags = '0; m_irq = '0; h_eq = '0; h_pend = '0;
    end else begin
      s   = set_events(h_pend);
      nf  = s | (m_flags & ~clr_events());
      eqn = {cnt_val == 16'd0, cnt_val == cap_val, cnt_val == cmp_b_val, cnt_val == cmp_a_val};
      h_pend = eqn & ~h_eq & ~{2'b00, force_b, force_a};
      h_eq   = eqn;
      m_flags = nf;
      m_irq   = nf & irq_mask;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic model_cmp();
    chk("R2 capture flag vs model", flags[3], m_flags[3]);
    chk("R4 compare flags vs model", flags[2:1], m_flags[2:1]);
    chk("R6 overflow flag vs model", flags[0], m_flags[0]);
    chk("R11 irq vs model", irq, m_irq);
    chk("R12 read-back vs model", rd_data, {2'b00, m_flags, 2'b00});
  endtask

  task automatic quiet();
    cap_evt = 0; ovf_stb = 0; force_a = 0; force_b = 0; ack = '0; wr_en = 0; wr_data = '0;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    @(negedge clk); cyc();
    // R1: reset state
    chk("R1 flags in reset", flags, 4'h0);
    chk("R1 irq in reset", irq, 4'h0);
    chk("R1 rd_data in reset", rd_data, 8'h00);
    rst = 0; cnt_val = 16'd1;
    cyc();
    chk("R1 flags after release", flags, 4'h0);

    // R2: capture pin event
    cap_evt = 1; cyc(); quiet();
    chk("R2 capture on event", flags[3], 1'b1);
    // R12: layout
    chk("R12 capture at bit 5", rd_data, 8'h20);
    // R9: zero in bit 5 keeps it, one clears it
    wr_en = 1; wr_data = 8'hDF; cyc(); quiet();
    chk("R9 zero write keeps flag", flags[3], 1'b1);
    wr_en = 1; wr_data = 8'h20; cyc(); quiet();
    chk("R9 write one clears", flags[3], 1'b0);

    // R4: compare A held match sets once
    cnt_val = 16'd5; cmp_a_val = 16'd5; cyc();
    chk("R4 compare A not yet", flags[2], 1'b0);
    cyc();
    chk("R4 compare A set after match", flags[2], 1'b1);
    ack = 4'b0100; cyc(); quiet();
    chk("R8 ack clears compare A", flags[2], 1'b0);
    cyc(); cyc();
    chk("R4 held match not re-set", flags[2], 1'b0);

    // R5: forced compare absorbs the first match cycle
    cnt_val = 16'd7; cmp_b_val = 16'd7; force_b = 1; cyc(); quiet();
    cyc(); cyc();
    chk("R5 forced compare no flag", flags[1], 1'b0);
    force_a = 1; cyc(); quiet(); cyc();
    chk("R5 force without match no flag", flags[2], 1'b0);

    // R6: overflow in normal mode
    ovf_stb = 1; cyc(); quiet();
    chk("R6 overflow set", flags[0], 1'b1);
    chk("R12 overflow at bit 2", rd_data, 8'h04);
    // R10: set beats acknowledge
    ovf_stb = 1; ack = 4'b0001; cyc(); quiet();
    chk("R10 set wins over ack", flags[0], 1'b1);
    ovf_stb = 1; wr_en = 1; wr_data = 8'h04; cyc(); quiet();
    chk("R10 set wins over write", flags[0], 1'b1);

    // R11: mask
    irq_mask = 4'b0001; cyc();
    chk("R11 irq follows mask", irq, 4'b0001);
    irq_mask = 4'b0000; cyc();
    chk("R11 irq masked off", irq, 4'b0000);
    ack = 4'b0001; cyc(); quiet();
    chk("R8 ack clears overflow", flags[0], 1'b0);

    // R7: PWM mode ignores strobe, sets at bottom
    mode = 2'd2; cnt_val = 16'd4; ovf_stb = 1; cyc(); quiet();
    chk("R7 strobe ignored in PWM", flags[0], 1'b0);
    cnt_val = 16'd0; cyc();
    chk("R7 bottom not yet", flags[0], 1'b0);
    cyc();
    chk("R7 bottom sets overflow", flags[0], 1'b1);

    // R3: capture register as TOP
    mode = 2'd0; cap_is_top = 1; cap_val = 16'd3; cnt_val = 16'd2;
    cap_evt = 1; cyc(); quiet();
    chk("R2 pin event ignored as TOP", flags[3], 1'b0);
    cnt_val = 16'd3; cyc();
    chk("R3 TOP not yet", flags[3], 1'b0);
    cyc();
    chk("R3 TOP sets capture", flags[3], 1'b1);
    cap_is_top = 0;

    // random phase against the model
    for (int n = 0; n < 3000; n++) begin
      if ($urandom % 2 == 0) cnt_val = 16'($urandom % 6);
      if ($urandom % 20 == 0) cmp_a_val = 16'($urandom % 6);
      if ($urandom % 20 == 0) cmp_b_val = 16'($urandom % 6);
      if ($urandom % 20 == 0) cap_val = 16'($urandom % 6);
      if ($urandom % 40 == 0) cap_is_top = ~cap_is_top;
      if ($urandom % 40 == 0) mode = 2'($urandom);
      if ($urandom % 10 == 0) irq_mask = 4'($urandom);
      cap_evt = ($urandom % 10 == 0);
      ovf_stb = ($urandom % 10 == 0);
      force_a = ($urandom % 20 == 0);
      force_b = ($urandom % 20 == 0);
      for (int b = 0; b < 4; b++) ack[b] = ($urandom % 15 == 0);
      wr_en = ($urandom % 15 == 0);
      wr_data = 8'($urandom);
      cyc();
      model_cmp();
    end

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule